// File: doc/BRIEF.md
# ADC Result Holding Register with Read Lock

This block keeps the latest 10-bit analog conversion result and shows it to a bus as two 8-bit read-only bytes, a low byte and a high byte. When a conversion finishes, the result is written into the pair in one of two layouts. In the right-aligned layout the value sits at the bottom of the 16-bit pair. In the left-aligned layout it sits at the top, so the eight most significant bits fill the high byte. The layout is picked by an alignment input, which is sampled at the moment of capture.

A reading of the low byte locks the pair. While the pair is locked, new conversions cannot write to it, so the two bytes a bus master reads always come from the same conversion. A reading of the high byte clears the lock. Reading only the high byte never locks the pair, so a master that needs only 8 bits in left-aligned mode can read the high byte alone. A conversion that arrives while the pair is locked is dropped, and a sticky flag records the loss until the next high-byte read. Signed (differential) results are kept as the same two's-complement bit pattern; the block does not interpret them.

Top module: `adcr_result_reg`

## Requirements
- R1: After synchronous reset both bytes read 0x00, the lost flag is 0 and the pair is unlocked.
- R2: With the alignment input low at capture, result bits 7:0 appear in the low byte and bits 9:8 in high-byte bits 1:0; high-byte bits 7:2 read zero.
- R3: With the alignment input high at capture, result bits 9:2 appear in the high byte and bits 1:0 in low-byte bits 7:6; low-byte bits 5:0 read zero.
- R4: A low-byte read (read strobe with byte select 0) locks the pair; no later conversion changes either byte until a high-byte read occurs.
- R5: A high-byte read (read strobe with byte select 1) clears the lock, and the next conversion is captured.
- R6: High-byte reads alone never lock the pair; each new conversion replaces the held value.
- R7: A conversion dropped because of the lock sets the lost flag one cycle later. The flag stays set until a high-byte read, and it reads 0 in the cycle after that read.
- R8: A change of the alignment input after capture does not reformat the held bytes.
- R9: A conversion in the same cycle as a low-byte read is dropped and counted as lost. A conversion in the same cycle as a high-byte read is captured, while that read still returns the old high byte.
- R10: Read data is combinational from the held pair: during a read strobe, rd_data shows the selected byte in that same cycle. The bit pattern of the result, including two's-complement values, is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: conversion result is valid |
| conv_value | input | 10 | Conversion result |
| align_left | input | 1 | 1 = left-aligned layout, 0 = right-aligned (sampled at capture) |
| rd_en | input | 1 | Bus read strobe |
| rd_hi_sel | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| rd_data | output | 8 | Selected byte, combinational |
| lost_flag | output | 1 | Sticky: a conversion was dropped while locked |

## Verification
The layouts are checked with asymmetric values (0x2A5, 0x155, 0x0AA) and with the all-ones pattern 0x3FF. A bit that lands in the wrong byte or the wrong position therefore shows up as a wrong byte value. The lock tests place the low read, the dropped conversion and the releasing high read in separate cycles, which separates "held" from "overwritten" and shows when the flag sets and clears. Same-cycle conversion-plus-read cases show which read direction blocks capture. A run of high-only reads, and an alignment toggle after capture, show that neither the lock nor the layout changes where the requirements say it must not.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int unsigned ADCR_RES_W  = 10;
  localparam int unsigned ADCR_BYTE_W = 8;
endpackage

// File: rtl/adcr_format.sv
module adcr_format #(
  parameter int unsigned RES_W  = adcr_pkg::ADCR_RES_W,
  parameter int unsigned BYTE_W = adcr_pkg::ADCR_BYTE_W
) (
  input  logic [RES_W-1:0]    value,
  input  logic                left,
  output logic [2*BYTE_W-1:0] word
);
  localparam int unsigned PAD = 2*BYTE_W - RES_W;

  generate
    if (PAD == 0) begin : g_full
      assign word = value;
      logic unused_left;
      assign unused_left = left;
    end else begin : g_pad
      always_comb begin
        if (left) word = {value, {PAD{1'b0}}};
        else      word = {{PAD{1'b0}}, value};
      end
    end
  endgenerate
endmodule

// File: rtl/adcr_lock_ctrl.sv
module adcr_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic capture,
  output logic locked,
  output logic lost
);
  logic blocked;

  // A high read frees the pair this cycle; a low read this cycle blocks capture.
  assign blocked = rd_lo | (locked & ~rd_hi);
  assign capture = conv_done & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      lost   <= 1'b0;
    end else begin
      if (rd_hi)      locked <= 1'b0;
      else if (rd_lo) locked <= 1'b1;

      if (conv_done & blocked) lost <= 1'b1;
      else if (rd_hi)          lost <= 1'b0;
    end
  end
endmodule

// File: rtl/adcr_hold.sv
module adcr_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/adcr_result_reg.sv
module adcr_result_reg #(
  parameter int unsigned RES_W  = adcr_pkg::ADCR_RES_W,
  parameter int unsigned BYTE_W = adcr_pkg::ADCR_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              align_left,
  input  logic              rd_en,
  input  logic              rd_hi_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lost_flag
);
  localparam int unsigned PAIR_W = 2*BYTE_W;

  logic              rd_lo;
  logic              rd_hi;
  logic              capture;
  logic              locked;
  logic [PAIR_W-1:0] fmt_word;
  logic [PAIR_W-1:0] held;

  assign rd_lo = rd_en & ~rd_hi_sel;
  assign rd_hi = rd_en &  rd_hi_sel;

  adcr_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .value (conv_value),
    .left  (align_left),
    .word  (fmt_word)
  );

  adcr_lock_ctrl u_lock (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .capture   (capture),
    .locked    (locked),
    .lost      (lost_flag)
  );

  adcr_hold #(.W(PAIR_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (capture),
    .d    (fmt_word),
    .q    (held)
  );

  assign rd_data = rd_hi_sel ? held[PAIR_W-1:BYTE_W] : held[BYTE_W-1:0];
endmodule

// File: rtl/adcr_result_chk.sv
module adcr_result_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                conv_done,
  input logic [RES_W-1:0]    conv_value,
  input logic                align_left,
  input logic                rd_en,
  input logic                rd_hi_sel,
  input logic                lost_flag,
  input logic                locked,
  input logic [2*BYTE_W-1:0] held
);
  localparam int unsigned PAD = 2*BYTE_W - RES_W;

  // R4: low read locks the pair
  p_lo_read_locks_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hi_sel) |=> locked);

  // R4: locked pair without a high read keeps its contents
  p_locked_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (locked && !(rd_en && rd_hi_sel)) |=> $stable(held));

  // R5: high read releases
  p_hi_read_frees_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi_sel) |=> !locked);

  // R7: dropped result raises the flag
  p_lost_set_r7: assert property (@(posedge clk) disable iff (rst)
    (conv_done && locked && !(rd_en && rd_hi_sel)) |=> lost_flag);

  // R7: high read clears the flag
  p_lost_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi_sel) |=> !lost_flag);

  // R9: conversion alongside a low read is lost
  p_lo_collide_r9: assert property (@(posedge clk) disable iff (rst)
    (conv_done && rd_en && !rd_hi_sel) |=> lost_flag);

  // R2: right-aligned capture
  p_right_fmt_r2: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !locked && !rd_en && !align_left) |=>
      (held == {{PAD{1'b0}}, $past(conv_value)}));

  // R3: left-aligned capture
  p_left_fmt_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !locked && !rd_en && align_left) |=>
      (held == {$past(conv_value), {PAD{1'b0}}}));
endmodule

bind adcr_result_reg adcr_result_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_done  (conv_done),
  .conv_value (conv_value),
  .align_left (align_left),
  .rd_en      (rd_en),
  .rd_hi_sel  (rd_hi_sel),
  .lost_flag  (lost_flag),
  .locked     (locked),
  .held       (held)
);

// File: tb/tb_adcr_result_reg.sv
`timescale 1ns/1ps
module tb_adcr_result_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic       align_left = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_hi_sel = 1'b0;
  logic [7:0] rd_data;
  logic       lost_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  adcr_result_reg dut (
    .clk (clk), .rst (rst), .conv_done (conv_done), .conv_value (conv_value),
    .align_left (align_left), .rd_en (rd_en), .rd_hi_sel (rd_hi_sel),
    .rd_data (rd_data), .lost_flag (lost_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [9:0] v, input logic left);
    @(negedge clk);
    conv_done = 1'b1; conv_value = v; align_left = left;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic read_byte(input logic hi, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_hi_sel = hi;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 lost", {15'd0, lost_flag}, 16'd0);
    read_byte(1'b0, d); check("R1 low", {8'd0, d}, 16'h00);
    read_byte(1'b1, d); check("R1 high", {8'd0, d}, 16'h00);
  endtask

  task automatic t_right();
    logic [7:0] d;
    conv(10'h2A5, 1'b0);
    read_byte(1'b0, d); check("R2 low", {8'd0, d}, 16'hA5);
    read_byte(1'b1, d); check("R2 high", {8'd0, d}, 16'h02);
    conv(10'h3FF, 1'b0);
    read_byte(1'b0, d); check("R10 low twos", {8'd0, d}, 16'hFF);
    read_byte(1'b1, d); check("R10 high twos", {8'd0, d}, 16'h03);
  endtask

  task automatic t_left();
    logic [7:0] d;
    conv(10'h2A5, 1'b1);
    read_byte(1'b0, d); check("R3 low", {8'd0, d}, 16'h40);
    read_byte(1'b1, d); check("R3 high", {8'd0, d}, 16'hA9);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    conv(10'h123, 1'b0);
    read_byte(1'b0, d); check("R4 low", {8'd0, d}, 16'h23);
    conv(10'h3C0, 1'b0);
    check("R7 lost set", {15'd0, lost_flag}, 16'd1);
    repeat (3) @(negedge clk);
    check("R7 lost sticky", {15'd0, lost_flag}, 16'd1);
    read_byte(1'b1, d); check("R4 high held", {8'd0, d}, 16'h01);
    check("R7 lost cleared", {15'd0, lost_flag}, 16'd0);
    conv(10'h3C0, 1'b0);
    check("R5 no loss after release", {15'd0, lost_flag}, 16'd0);
    read_byte(1'b0, d); check("R5 low new", {8'd0, d}, 16'hC0);
    read_byte(1'b1, d); check("R5 high new", {8'd0, d}, 16'h03);
  endtask

  task automatic t_hi_only();
    logic [7:0] d;
    conv(10'h155, 1'b1);
    read_byte(1'b1, d); check("R6 first", {8'd0, d}, 16'h55);
    conv(10'h0AA, 1'b1);
    read_byte(1'b1, d); check("R6 second", {8'd0, d}, 16'h2A);
    check("R6 no loss", {15'd0, lost_flag}, 16'd0);
  endtask

  task automatic t_align_change();
    logic [7:0] d;
    conv(10'h3A5, 1'b0);
    @(negedge clk); align_left = 1'b1;
    repeat (2) @(negedge clk);
    read_byte(1'b0, d); check("R8 low", {8'd0, d}, 16'hA5);
    read_byte(1'b1, d); check("R8 high", {8'd0, d}, 16'h03);
    align_left = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    conv(10'h111, 1'b0);
    @(negedge clk);
    rd_en = 1'b1; rd_hi_sel = 1'b0; conv_done = 1'b1; conv_value = 10'h2EE;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    check("R9 low read value", {8'd0, d}, 16'h11);
    check("R9 low collide lost", {15'd0, lost_flag}, 16'd1);
    read_byte(1'b1, d); check("R9 high kept", {8'd0, d}, 16'h01);
    read_byte(1'b0, d); check("R9 relock low", {8'd0, d}, 16'h11);
    @(negedge clk);
    rd_en = 1'b1; rd_hi_sel = 1'b1; conv_done = 1'b1; conv_value = 10'h0F0;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    check("R10 same-cycle high old", {8'd0, d}, 16'h01);
    check("R9 high collide no loss", {15'd0, lost_flag}, 16'd0);
    read_byte(1'b0, d); check("R9 captured low", {8'd0, d}, 16'hF0);
    read_byte(1'b1, d); check("R9 captured high", {8'd0, d}, 16'h00);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_right();
    t_left();
    t_lock();
    t_hi_only();
    t_align_change();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule